// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block is one bank of a general-purpose I/O controller. It groups 32 pins into four ports of eight pins. Each port has a pin-enable register, an output-enable register, an output-value register and a synchronized input register. It also keeps interrupt-enable and interrupt-type storage, which a separate edge/level detector uses. Software reaches the block over a simple single-cycle 32-bit register bus: address, write strobe, write data, and combinational read data.

Every writable register has two aliases. The plain alias replaces the whole register. The masked alias sits 0x800 above the plain one. In that alias, the upper byte of the written word chooses which bits the lower byte updates. A driver can therefore change one pin without a read-modify-write sequence, and two agents touching different pins of the same port never overwrite each other.

Pads appear as three 32-bit vectors. A pin is driven only when its pin-enable bit and its output-enable bit are both set. Otherwise it is released and its output value reads as 0. To bring a pin up as an output cleanly, software writes the output level first and sets output-enable after it.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, pin_out, pin_oe, irq_enable, irq_type and irq_clear are all zero, and reads of every pin-enable, output-enable and output-value register return 0.
- R2: Decoding works as follows. Address bits [3:2] select the port. Bits [6:4] select the register: 0 pin-enable, 1 output-enable, 2 output-value, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 interrupt clear. Bit 11 selects the masked alias. Bits [10:7] and [1:0] must be zero. Any other access is ignored and reads 0.
- R3: A plain write replaces the selected 8-bit register with write data bits [7:0].
- R4: In a masked write, data bit 8+n enables an update of register bit n, and data bit n is the new value. Bits whose enable is 0 keep their value.
- R5: pin_oe[i] is 1 exactly when pin-enable bit i and output-enable bit i are both 1. pin_out[i] equals output-value bit i when pin_oe[i] is 1 and is 0 otherwise.
- R6: pin_in passes through two flip-flops before the input register. A read of the input register returns pin levels from two clock edges earlier. Writes to the input offset in either alias have no effect.
- R7: A read of a masked alias returns the same value as the plain alias.
- R8: The interrupt-enable registers drive irq_enable, with port p in bits [8p+7:8p]. Both aliases write them.
- R9: The interrupt-type register is 24 bits per port and drives irq_type[24p+23:24p]. A plain write stores data bits [23:0]. A masked write updates only bits [7:0], using the R4 rule, and leaves bits [23:8] unchanged.
- R10: A read of the interrupt-status register returns irq_status bits [8p+7:8p] for the addressed port.
- R11: A plain write to interrupt-clear raises irq_clear[8p+n] for exactly the one cycle after the write, for each set data bit n. A masked write to that offset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad drive enables |
| irq_status | input | 32 | Pending flags from the detector |
| irq_enable | output | 32 | Interrupt enables to the detector |
| irq_type | output | 96 | Interrupt type fields, 24 bits per port |
| irq_clear | output | 32 | One-cycle clear pulses to the detector |

## Verification
Several corner cases are targeted directly. A masked write with an all-zero enable byte must leave the register untouched; a design that treated the alias as a plain write would clear or set the whole port. Writes to the input offset, a masked write to interrupt-clear, and an address with a nonzero bank field must all be inert; mis-decoding would corrupt the output-value or enable registers, or emit stray clear pulses. The bench times input sampling edge by edge, so a missing or extra synchronizer stage shows up as a read one cycle early or late. A masked write of the interrupt type must leave its upper 16 bits intact.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NPORTS = 4,
  parameter int PW     = 8,
  parameter int TW     = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NPORTS*PW-1:0] pin_in,
  output logic [NPORTS*PW-1:0] pin_out,
  output logic [NPORTS*PW-1:0] pin_oe,
  input  logic [NPORTS*PW-1:0] irq_status,
  output logic [NPORTS*PW-1:0] irq_enable,
  output logic [NPORTS*TW-1:0] irq_type,
  output logic [NPORTS*PW-1:0] irq_clear
);
  localparam int PINS = NPORTS * PW;

  logic [PW-1:0] cnf_q [NPORTS];
  logic [PW-1:0] oe_q  [NPORTS];
  logic [PW-1:0] out_q [NPORTS];
  logic [PW-1:0] enb_q [NPORTS];
  logic [TW-1:0] lvl_q [NPORTS];
  logic [PINS-1:0] sync1_q, sync2_q;

  logic       valid, masked;
  logic [2:0] rsel;
  logic [1:0] psel;
  logic       unused_bits;

  assign valid       = (bus_addr[10:7] == 4'd0) && (bus_addr[1:0] == 2'd0);
  assign masked      = bus_addr[11];
  assign rsel        = bus_addr[6:4];
  assign psel        = bus_addr[3:2];
  assign unused_bits = ^bus_wdata[31:TW];

  function automatic logic [PW-1:0] merge(input logic [PW-1:0] old, input logic [31:0] d);
    return (old & ~d[2*PW-1:PW]) | (d[PW-1:0] & d[2*PW-1:PW]);
  endfunction

  function automatic logic [PW-1:0] wval(input logic [PW-1:0] old, input logic [31:0] d,
                                         input logic msk);
    return msk ? merge(old, d) : d[PW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = bus_we && valid && (psel == 2'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnf_q[p] <= '0;
        oe_q[p]  <= '0;
        out_q[p] <= '0;
        enb_q[p] <= '0;
        lvl_q[p] <= '0;
        irq_clear[p*PW +: PW] <= '0;
      end else begin
        if (hit && rsel == 3'd0) cnf_q[p] <= wval(cnf_q[p], bus_wdata, masked);
        if (hit && rsel == 3'd1) oe_q[p]  <= wval(oe_q[p],  bus_wdata, masked);
        if (hit && rsel == 3'd2) out_q[p] <= wval(out_q[p], bus_wdata, masked);
        if (hit && rsel == 3'd5) enb_q[p] <= wval(enb_q[p], bus_wdata, masked);
        if (hit && rsel == 3'd6)
          lvl_q[p] <= masked ? {lvl_q[p][TW-1:PW], merge(lvl_q[p][PW-1:0], bus_wdata)}
                             : bus_wdata[TW-1:0];
        irq_clear[p*PW +: PW] <= (hit && rsel == 3'd7 && !masked) ? bus_wdata[PW-1:0] : '0;
      end
    end

    assign pin_oe[p*PW +: PW]     = cnf_q[p] & oe_q[p];
    assign pin_out[p*PW +: PW]    = out_q[p] & cnf_q[p] & oe_q[p];
    assign irq_enable[p*PW +: PW] = enb_q[p];
    assign irq_type[p*TW +: TW]   = lvl_q[p];
  end

  always_comb begin
    bus_rdata = '0;
    if (valid) begin
      case (rsel)
        3'd0: bus_rdata[PW-1:0] = cnf_q[psel];
        3'd1: bus_rdata[PW-1:0] = oe_q[psel];
        3'd2: bus_rdata[PW-1:0] = out_q[psel];
        3'd3: bus_rdata[PW-1:0] = sync2_q[psel*PW +: PW];
        3'd4: bus_rdata[PW-1:0] = irq_status[psel*PW +: PW];
        3'd5: bus_rdata[PW-1:0] = enb_q[psel];
        3'd6: bus_rdata[TW-1:0] = lvl_q[psel];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module gpio_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_in,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic [31:0] irq_status,
  input logic [31:0] irq_enable,
  input logic [95:0] irq_type,
  input logic [31:0] irq_clear
);
  logic [1:0] age_q;
  logic       clr_wr, in_wr, nop_msk;

  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign clr_wr  = bus_we && bus_addr == 12'h078;
  assign in_wr   = bus_we && bus_addr[6:4] == 3'd3;
  assign nop_msk = bus_we && bus_addr[11] && bus_wdata[15:8] == 8'd0;

  // R4
  masked_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_msk |=> $stable(pin_out) && $stable(pin_oe) && $stable(irq_enable) && $stable(irq_type));

  // R6
  in_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |=> $stable(pin_out) && $stable(pin_oe) && $stable(irq_enable) && $stable(irq_type));

  // R6
  in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && bus_addr == 12'h030) |-> bus_rdata[7:0] == $past(pin_in[7:0], 2));

  // R11
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> irq_clear[23:16] == $past(bus_wdata[7:0]));

  // R11
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> irq_clear == 32'd0);

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_oe) && $stable(pin_out));
endmodule

bind gpio_bank_regs gpio_bank_chk u_chk (.*);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [31:0] irq_status = '0;
  logic [31:0] irq_enable, irq_clear;
  logic [95:0] irq_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_regs i_gpio_bank_regs (.*);

  // {address, write data, expected pin_out, expected pin_oe}
  localparam int NV = 16;
  localparam logic [107:0] VEC [NV] = '{
    {12'h020, 32'h000000A5, 32'h00000000, 32'h00000000},
    {12'h000, 32'h000000FF, 32'h00000000, 32'h00000000},
    {12'h810, 32'h00000F0F, 32'h00000005, 32'h0000000F},
    {12'h820, 32'h00000300, 32'h00000004, 32'h0000000F},
    {12'h820, 32'h000000FF, 32'h00000004, 32'h0000000F},
    {12'h800, 32'h00000400, 32'h00000000, 32'h0000000B},
    {12'h014, 32'h0000003C, 32'h00000000, 32'h0000000B},
    {12'h004, 32'h000000FF, 32'h00000000, 32'h00003C0B},
    {12'h824, 32'h0000FFFF, 32'h00003C00, 32'h00003C0B},
    {12'h01C, 32'h00000081, 32'h00003C00, 32'h00003C0B},
    {12'h00C, 32'h00000080, 32'h00003C00, 32'h80003C0B},
    {12'h02C, 32'h000000FF, 32'h80003C00, 32'h80003C0B},
    {12'h030, 32'h000000FF, 32'h80003C00, 32'h80003C0B},
    {12'h830, 32'h0000FFFF, 32'h80003C00, 32'h80003C0B},
    {12'h810, 32'h00000F00, 32'h80003C00, 32'h80003C00},
    {12'h0A0, 32'h000000FF, 32'h80003C00, 32'h80003C00}
  };

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq_enable", irq_enable, 0);
    chk("R1 irq_type", irq_type, 0);
    chk("R1 irq_clear", irq_clear, 0);
    rd(12'h028, r); chk("R1 out read", r, 0);

    // R2 R3 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][107:96], VEC[i][95:64]);
      chk($sformatf("R5 vec%0d pin_out", i), pin_out, VEC[i][63:32]);
      chk($sformatf("R5 vec%0d pin_oe", i), pin_oe, VEC[i][31:0]);
    end

    // R3 R4 R7 readback through both aliases
    rd(12'h000, r); chk("R4 cnf0 plain read", r, 32'hFB);
    rd(12'h800, r); chk("R7 cnf0 masked read", r, 32'hFB);
    rd(12'h020, r); chk("R4 out0 read", r, 32'hA4);
    rd(12'h024, r); chk("R3 out1 read", r, 32'hFF);
    rd(12'h0A0, r); chk("R2 bank field read", r, 0);
    rd(12'h022, r); chk("R2 low bits read", r, 0);

    // R6 synchronizer latency
    @(negedge clk);
    pin_in = 32'h12345678;
    @(negedge clk);
    rd(12'h030, r); chk("R6 in after one edge", r, 0);
    @(negedge clk);
    rd(12'h030, r); chk("R6 in after two edges", r, 32'h78);
    rd(12'h838, r); chk("R6 R7 in port2 masked alias", r, 32'h34);

    // R8 interrupt enables
    wr(12'h050, 32'h0F);
    wr(12'h85C, 32'h8080);
    chk("R8 irq_enable", irq_enable, 96'h8000000F);
    rd(12'h05C, r); chk("R8 enb3 read", r, 32'h80);

    // R9 interrupt type
    wr(12'h064, 32'hFF123456);
    chk("R9 plain type", irq_type[47:24], 24'h123456);
    wr(12'h864, 32'h0F0F);
    chk("R9 masked type", irq_type[47:24], 24'h12345F);
    rd(12'h064, r); chk("R9 type read", r, 32'h12345F);

    // R10 status passthrough
    irq_status = 32'hDEADBEEF;
    rd(12'h044, r); chk("R10 status port1", r, 32'hBE);
    rd(12'h84C, r); chk("R10 status port3 masked", r, 32'hDE);

    // R11 clear pulses
    wr(12'h078, 32'h5A);
    chk("R11 clear pulse", irq_clear, 32'h005A0000);
    @(negedge clk);
    chk("R11 clear drops", irq_clear, 0);
    wr(12'h878, 32'hFFFF);
    chk("R11 masked clear inert", irq_clear, 0);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset pin_oe", pin_oe, 0);
    chk("R1 reset irq_type", irq_type, 0);
    rd(12'h024, r); chk("R1 reset out1 read", r, 0);

    finish_run();
  end
endmodule